// File: doc/BRIEF.md
# Converter Start Trigger Selector

This block decides when an analog-to-digital converter controller starts a single conversion, and it emits that decision as a one-cycle start pulse. Software writes a small configuration word with a write strobe. The word holds a 3-bit start code and an edge polarity bit. Code 0 keeps the block idle. Code 1 starts a conversion at once, when the word is written. Codes 2 through 7 each pick one of six external trigger lines: two captured pin levels and four timer match outputs. The conversion then starts on the chosen edge of that line.

Each trigger line may be asynchronous to the local clock. Every line passes through its own synchronizer and edge detector, and all lines are watched in parallel. Changing the selected line therefore never produces an edge out of stale history.

The controller drives a busy flag while a conversion is in progress. A start request that arrives while busy is high is dropped and is not kept for later. While the controller's burst flag is high, the block produces no pulses at all.

Top module: `adc_start_trigger_sel`

## Requirements
- R1: While `rst` is high, `start_pulse` is low on the next clock. Reset sets the stored code to 0 and the stored polarity to falling.
- R2: With stored code 0, no trigger edge on any line produces a start pulse.
- R3: A write (`cfg_wr` high) of code 1 gives `start_pulse` high for exactly the one cycle after that clock edge. No further pulse follows while code 1 stays stored and no new write occurs.
- R4: Stored code k, for k from 2 to 7, selects trigger line `trig_in[k-2]`. Edges on every other line are ignored.
- R5: Stored polarity 1 starts on a rising edge of the selected line, and polarity 0 starts on a falling edge. The opposite edge produces no pulse.
- R6: A level change on the selected line is seen by two synchronizer flops and one edge history flop. The pulse is therefore high in the cycle after the third rising clock edge following the change, and it stays high for that one cycle only.
- R7: While `burst_en` is high at a clock edge, `start_pulse` is low in the following cycle, whatever the code or the trigger activity.
- R8: A start request (an immediate write or a selected edge) that would raise `start_pulse` at an edge where `conv_busy` is high is discarded. No pulse appears for it later.
- R9: The polarity bit has no effect for codes 0 and 1. A code-1 write pulses with either polarity value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the start code and polarity |
| cfg_code | input | CODE_W (3) | Start code: 0 idle, 1 immediate, 2..7 trigger line 0..5 |
| cfg_rise | input | 1 | Edge polarity: 1 rising, 0 falling |
| burst_en | input | 1 | Burst mode flag; suppresses all start pulses |
| conv_busy | input | 1 | Conversion in progress; requests are dropped |
| trig_in | input | NUM_SRC (6) | Asynchronous external trigger lines |
| start_pulse | output | 1 | Registered one-cycle conversion start |

## Verification
The properties assume the following about the inputs. Trigger lines hold each level for at least two clock periods. The stored code changes only through `cfg_wr`. `conv_busy` and `burst_en` are synchronous to `clk`. The stimulus changes every input a short delay after the rising clock edge and holds each trigger baseline for several cycles before toggling one line. It also returns the block to code 0 before moving the baseline levels, so that settling edges never fall on a selected line.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  // Start code meanings; codes at or above EDGE_BASE select a trigger line.
  localparam int CODE_IDLE = 0;
  localparam int CODE_NOW  = 1;
  localparam int EDGE_BASE = 2;

  typedef struct packed {
    logic rise_ev;
    logic fall_ev;
  } edge_ev_t;
endpackage

// File: rtl/trig_sync_bank.sv
module trig_sync_bank
  import adc_trig_pkg::*;
#(
  parameter int NUM_SRC     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SRC-1:0]   trig_in,
  output edge_ev_t             ev [NUM_SRC]
);
  localparam int LAST = SYNC_STAGES - 1;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_line
    logic [SYNC_STAGES-1:0] chain;
    logic                   hist;

    always_ff @(posedge clk) begin
      if (rst) begin
        chain <= '0;
        hist  <= 1'b0;
      end else begin
        chain <= {chain[SYNC_STAGES-2:0], trig_in[g]};
        hist  <= chain[LAST];
      end
    end

    assign ev[g].rise_ev =  chain[LAST] & ~hist;
    assign ev[g].fall_ev = ~chain[LAST] &  hist;
  end
endmodule

// File: rtl/trig_src_select.sv
module trig_src_select
  import adc_trig_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int CODE_W  = 3
) (
  input  logic [CODE_W-1:0] code_q,
  input  logic              rise_q,
  input  edge_ev_t          ev [NUM_SRC],
  output logic              edge_hit
);
  always_comb begin
    edge_hit = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (code_q == CODE_W'(EDGE_BASE + i))
        edge_hit = rise_q ? ev[i].rise_ev : ev[i].fall_ev;
    end
  end
endmodule

// File: rtl/start_pulse_gen.sv
module start_pulse_gen (
  input  logic clk,
  input  logic rst,
  input  logic imm_req,
  input  logic edge_hit,
  input  logic burst_en,
  input  logic conv_busy,
  output logic start_pulse
);
  logic want;
  assign want = (imm_req | edge_hit) & ~burst_en & ~conv_busy;

  always_ff @(posedge clk) begin
    if (rst) start_pulse <= 1'b0;
    else     start_pulse <= want;
  end
endmodule

// File: rtl/adc_start_trigger_sel.sv
module adc_start_trigger_sel
  import adc_trig_pkg::*;
#(
  parameter int NUM_SRC     = 6,
  parameter int SYNC_STAGES = 2,
  parameter int CODE_W      = $clog2(NUM_SRC + EDGE_BASE)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic [CODE_W-1:0]  cfg_code,
  input  logic               cfg_rise,
  input  logic               burst_en,
  input  logic               conv_busy,
  input  logic [NUM_SRC-1:0] trig_in,
  output logic               start_pulse
);
  logic [CODE_W-1:0] code_q;
  logic              rise_q;
  logic              imm_req;
  logic              edge_hit;
  edge_ev_t          ev [NUM_SRC];

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= CODE_W'(CODE_IDLE);
      rise_q <= 1'b0;
    end else if (cfg_wr) begin
      code_q <= cfg_code;
      rise_q <= cfg_rise;
    end
  end

  assign imm_req = cfg_wr && (cfg_code == CODE_W'(CODE_NOW));

  trig_sync_bank #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .trig_in(trig_in), .ev(ev)
  );

  trig_src_select #(.NUM_SRC(NUM_SRC), .CODE_W(CODE_W)) u_sel (
    .code_q(code_q), .rise_q(rise_q), .ev(ev), .edge_hit(edge_hit)
  );

  start_pulse_gen u_pulse (
    .clk(clk), .rst(rst), .imm_req(imm_req), .edge_hit(edge_hit),
    .burst_en(burst_en), .conv_busy(conv_busy), .start_pulse(start_pulse)
  );
endmodule

// File: rtl/adc_start_trigger_sel_chk.sv
module adc_start_trigger_sel_chk #(
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_wr,
  input logic [CODE_W-1:0] cfg_code,
  input logic              burst_en,
  input logic              conv_busy,
  input logic [CODE_W-1:0] code_q,
  input logic              start_pulse
);
  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !start_pulse);

  p_idle_silent_r2: assert property (@(posedge clk) disable iff (rst)
    (code_q == '0 && !cfg_wr) |=> !start_pulse);

  p_now_fires_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_code == CODE_W'(1) && !burst_en && !conv_busy) |=> start_pulse);

  p_now_no_repeat_r3: assert property (@(posedge clk) disable iff (rst)
    (code_q == CODE_W'(1) && !cfg_wr) |=> !start_pulse);

  p_burst_gate_r7: assert property (@(posedge clk) disable iff (rst)
    burst_en |=> !start_pulse);

  p_busy_drop_r8: assert property (@(posedge clk) disable iff (rst)
    conv_busy |=> !start_pulse);
endmodule

bind adc_start_trigger_sel adc_start_trigger_sel_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_code(cfg_code),
  .burst_en(burst_en), .conv_busy(conv_busy), .code_q(code_q),
  .start_pulse(start_pulse)
);

// File: tb/sim_adc_start_trigger_sel.sv
module sim_adc_start_trigger_sel;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [2:0] cfg_code = 3'd0;
  logic       cfg_rise = 1'b0;
  logic       burst_en = 1'b0;
  logic       conv_busy = 1'b0;
  logic [5:0] trig_in = 6'd0;
  logic       start_pulse;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  adc_start_trigger_sel u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_code(cfg_code),
    .cfg_rise(cfg_rise), .burst_en(burst_en), .conv_busy(conv_busy),
    .trig_in(trig_in), .start_pulse(start_pulse)
  );

  // fields: [9:7] code, [6] polarity, [5:3] line, [2] toggle rises, [1] burst, [0] expected
  localparam int NV = 12;
  localparam logic [9:0] VEC [NV] = '{
    {3'd2, 1'b1, 3'd0, 1'b1, 1'b0, 1'b1},
    {3'd2, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0},
    {3'd2, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1},
    {3'd3, 1'b1, 3'd1, 1'b1, 1'b0, 1'b1},
    {3'd3, 1'b1, 3'd0, 1'b1, 1'b0, 1'b0},
    {3'd4, 1'b0, 3'd2, 1'b0, 1'b0, 1'b1},
    {3'd5, 1'b1, 3'd3, 1'b1, 1'b0, 1'b1},
    {3'd6, 1'b1, 3'd4, 1'b1, 1'b0, 1'b1},
    {3'd7, 1'b0, 3'd5, 1'b0, 1'b0, 1'b1},
    {3'd7, 1'b1, 3'd5, 1'b1, 1'b1, 1'b0},
    {3'd0, 1'b1, 3'd0, 1'b1, 1'b0, 1'b0},
    {3'd5, 1'b1, 3'd2, 1'b1, 1'b0, 1'b0}
  };

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [2:0] code, input logic pol);
    cfg_wr = 1'b1; cfg_code = code; cfg_rise = pol;
    step();
    cfg_wr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    check("R1 reset pulse low", int'(start_pulse), 0);
    rst = 1'b0;
    step();

    // table walk: R4 R5 R6 R2 R7
    for (int v = 0; v < NV; v++) begin
      logic [2:0] code; logic pol; logic [2:0] line; logic up; logic bst; logic ex;
      int early;
      string tag;
      {code, pol, line, up, bst, ex} = VEC[v];
      if (bst) tag = "R7 burst";
      else if (code == 3'd0) tag = "R2 idle";
      else if (!ex && (32'(code) - 2 != 32'(line))) tag = "R4 unselected line";
      else if (!ex) tag = "R5 wrong edge";
      else tag = "R4/R5 selected edge";
      write_cfg(3'd0, 1'b0);
      trig_in = up ? 6'd0 : 6'h3f;
      repeat (5) step();
      write_cfg(code, pol);
      burst_en = bst;
      step();
      trig_in[line] = up;
      early = 0;
      step(); early += int'(start_pulse);
      step(); early += int'(start_pulse);
      step();
      check(tag, int'(start_pulse), int'(ex));
      step(); early += int'(start_pulse);
      step(); early += int'(start_pulse);
      check("R6 single pulse at third edge", early, 0);
      burst_en = 1'b0;
    end

    // R3 / R9 immediate start, both polarities, no repeat
    for (int p = 0; p < 2; p++) begin
      int later;
      write_cfg(3'd1, p[0]);
      check(p == 0 ? "R3 immediate pulse pol0 R9" : "R3 immediate pulse pol1 R9",
            int'(start_pulse), 1);
      later = 0;
      for (int k = 0; k < 6; k++) begin
        trig_in = trig_in ^ 6'h3f;
        step();
        later += int'(start_pulse);
      end
      check("R3 no repeat", later, 0);
    end

    // R7 immediate write during burst
    burst_en = 1'b1;
    write_cfg(3'd1, 1'b1);
    check("R7 immediate blocked by burst", int'(start_pulse), 0);
    burst_en = 1'b0;
    step();
    check("R7 not deferred", int'(start_pulse), 0);

    // R8 immediate write while busy, then busy released
    begin
      int later;
      conv_busy = 1'b1;
      write_cfg(3'd1, 1'b0);
      check("R8 immediate dropped while busy", int'(start_pulse), 0);
      conv_busy = 1'b0;
      later = 0;
      repeat (4) begin step(); later += int'(start_pulse); end
      check("R8 not queued", later, 0);
    end

    // R8 edge request while busy
    begin
      int later;
      write_cfg(3'd0, 1'b0);
      trig_in = 6'd0;
      repeat (5) step();
      write_cfg(3'd2, 1'b1);
      step();
      trig_in[0] = 1'b1;
      step(); step();
      conv_busy = 1'b1;
      step();
      check("R8 edge dropped while busy", int'(start_pulse), 0);
      conv_busy = 1'b0;
      later = 0;
      repeat (4) begin step(); later += int'(start_pulse); end
      check("R8 edge not queued", later, 0);
    end

    // R1 reset clears stored code: a rising edge on line 0 after reset is ignored
    begin
      int later;
      write_cfg(3'd2, 1'b1);
      trig_in = 6'd0;
      repeat (4) step();
      rst = 1'b1;
      step();
      check("R1 pulse low in reset", int'(start_pulse), 0);
      rst = 1'b0;
      repeat (3) step();
      trig_in[0] = 1'b1;
      later = 0;
      repeat (5) begin step(); later += int'(start_pulse); end
      check("R1 stored code cleared", later, 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule